// File: doc/BRIEF.md
# CMOS RAM Index Port with NMI Gate

This block is the legacy I/O front end of a 128-byte battery-backed CMOS RAM. Software first writes an index byte to I/O address 70h. Bits 6:0 of that byte pick a RAM location, and bit 7 is a mask that stops non-maskable interrupts. Software then moves the selected byte through the data port at 71h. A third port, at 72h, sits on the same seven address bits. Software can both write and read it. Its top bit on readback depends on which of the two index ports was written last.

Two error sources, an I/O channel check and a system error, reach the processor as an NMI request only while the mask bit is clear. The mask bit is also driven on its own output so that a status register elsewhere can mirror it. Reads return data one cycle after the request, with a one-cycle valid strobe.

Top module: `cmos_index_port`

## Requirements
- R1: After reset the NMI mask reads as set (`nmiDisable`=1), so `nmiReq` stays 0 even with both error inputs high. A read of 72h returns 00h.
- R2: A write to 70h loads data bit 7 into `nmiDisable` and data bits 6:0 into the shared RAM address. Both are visible from the next cycle.
- R3: A read of 70h returns FFh, because that port is write-only.
- R4: A write to 71h stores the data byte at the RAM location selected by the current 7-bit address. A read of 71h returns that byte. Every location from 00h to 7Fh is reachable.
- R5: If the latest index write went to 70h, a read of 72h returns {0, address[6:0]}. Bit 7 reads 0 even if an earlier 72h write set it.
- R6: If the latest index write went to 72h, a read of 72h returns all 8 bits exactly as written.
- R7: A write to 72h changes the shared RAM address that 71h uses and leaves `nmiDisable` unchanged.
- R8: `nmiReq` equals (`iochkErr` OR `serrErr`) AND NOT `nmiDisable`. It is combinational from the error inputs.
- R9: Every read strobe gives `ioRdValid` high for exactly the next cycle, with the data on `ioRdData`. Addresses other than 70h, 71h and 72h read FFh and ignore writes. The full 16-bit address is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the access |
| ioWrEn | input | 1 | Write strobe, one cycle per write |
| ioWrData | input | 8 | Write data |
| ioRdEn | input | 1 | Read strobe, one cycle per read |
| ioRdData | output | 8 | Read data, valid with ioRdValid |
| ioRdValid | output | 1 | High the cycle after a read strobe |
| iochkErr | input | 1 | I/O channel check error source |
| serrErr | input | 1 | System error source |
| nmiReq | output | 1 | Gated NMI request to the processor |
| nmiDisable | output | 1 | Current NMI mask bit, for mirroring |

## Verification
The bench writes FFh to 72h and then 7Fh to 70h. It expects 72h to read 7Fh. A design that keeps bit 7 from the earlier alternate write, rather than following the last writer, returns FFh here.

A write to 72h with bit 7 set must leave the NMI mask clear. A design that wires the two ports' top bits together would silence NMI at that point.

The bench uses addresses 00h and 7Fh to catch a truncated RAM index. It writes to 73h and to 170h and then rereads the RAM and 72h. A partial address decode corrupts state that those reads expose.

// File: rtl/cmos_idx_pkg.sv
package cmos_idx_pkg;

  // One-cycle strobes from the decode logic to the datapath.
  typedef struct packed {
    logic wrLegacy;  // write to the NMI/index port
    logic wrAlt;     // write to the alternate index port
    logic wrRam;     // write to the data port
    logic rdRam;     // read of the data port
    logic rdAlt;     // read of the alternate index port
    logic rdAny;     // any read strobe, mapped or not
  } portStrobe_t;

  // Which index port wrote the shared register most recently.
  typedef enum logic {
    WR_LEGACY = 1'b0,
    WR_ALT    = 1'b1
  } lastWriter_t;

endpackage

// File: rtl/cmos_ctrl.sv
module cmos_ctrl
  import cmos_idx_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] LEGACY_PORT = 16'h0070,
  parameter logic [15:0] DATA_PORT   = 16'h0071,
  parameter logic [15:0] ALT_PORT    = 16'h0072
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  output portStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] LegacyHit = ADDR_W'(LEGACY_PORT);
  localparam logic [ADDR_W-1:0] DataHit   = ADDR_W'(DATA_PORT);
  localparam logic [ADDR_W-1:0] AltHit    = ADDR_W'(ALT_PORT);

  logic hitLegacy;
  logic hitData;
  logic hitAlt;

  always_comb begin
    hitLegacy = (ioAddr == LegacyHit);
    hitData   = (ioAddr == DataHit);
    hitAlt    = (ioAddr == AltHit);
  end

  always_comb begin
    strobe          = '0;
    strobe.wrLegacy = ioWrEn && hitLegacy;
    strobe.wrAlt    = ioWrEn && hitAlt;
    strobe.wrRam    = ioWrEn && hitData;
    strobe.rdRam    = ioRdEn && hitData;
    strobe.rdAlt    = ioRdEn && hitAlt;
    strobe.rdAny    = ioRdEn;
  end

endmodule

// File: rtl/cmos_datapath.sv
module cmos_datapath
  import cmos_idx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RAM_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              iochkErr,
  input  logic              serrErr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              nmiReq,
  output logic              nmiDisable
);

  localparam int IDX_W = $clog2(RAM_DEPTH);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic                 nmiMaskQ;
  logic [IDX_W-1:0]     ramAddrQ;
  logic                 altTopQ;
  lastWriter_t          lastWriterQ;
  logic [DATA_W-1:0]    ramMem [RAM_DEPTH];
  logic [DATA_W-1:0]    altView;
  logic [DATA_W-1:0]    rdMux;
  logic [DATA_W-1:0]    rdDataQ;
  logic                 rdValidQ;

  // The index register is shared by both index ports. A legacy write also
  // loads the NMI mask bit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiMaskQ    <= 1'b1;
      ramAddrQ    <= '0;
      altTopQ     <= 1'b0;
      lastWriterQ <= WR_LEGACY;
    end else if (strobe.wrLegacy) begin
      nmiMaskQ    <= wrData[DATA_W-1];
      ramAddrQ    <= wrData[IDX_W-1:0];
      lastWriterQ <= WR_LEGACY;
    end else if (strobe.wrAlt) begin
      ramAddrQ    <= wrData[IDX_W-1:0];
      altTopQ     <= wrData[DATA_W-1];
      lastWriterQ <= WR_ALT;
    end
  end

  // RAM contents are not reset.
  always_ff @(posedge clk) begin
    if (strobe.wrRam) begin
      ramMem[ramAddrQ] <= wrData;
    end
  end

  always_comb begin
    altView = '0;
    altView[IDX_W-1:0] = ramAddrQ;
    if (lastWriterQ == WR_ALT) begin
      altView[DATA_W-1] = altTopQ;
    end
  end

  always_comb begin
    if (strobe.rdRam) begin
      rdMux = ramMem[ramAddrQ];
    end else if (strobe.rdAlt) begin
      rdMux = altView;
    end else begin
      rdMux = ALL_ONES;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strobe.rdAny;
      if (strobe.rdAny) begin
        rdDataQ <= rdMux;
      end
    end
  end

  assign rdData     = rdDataQ;
  assign rdValid    = rdValidQ;
  assign nmiDisable = nmiMaskQ;
  assign nmiReq     = (iochkErr || serrErr) && !nmiMaskQ;

endmodule

// File: rtl/cmos_index_port.sv
module cmos_index_port
  import cmos_idx_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int RAM_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              ioRdEn,
  output logic [DATA_W-1:0] ioRdData,
  output logic              ioRdValid,
  input  logic              iochkErr,
  input  logic              serrErr,
  output logic              nmiReq,
  output logic              nmiDisable
);

  portStrobe_t strobe;

  cmos_ctrl #(
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .ioAddr(ioAddr),
    .ioWrEn(ioWrEn),
    .ioRdEn(ioRdEn),
    .strobe(strobe)
  );

  cmos_datapath #(
    .DATA_W   (DATA_W),
    .RAM_DEPTH(RAM_DEPTH)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (ioWrData),
    .iochkErr  (iochkErr),
    .serrErr   (serrErr),
    .rdData    (ioRdData),
    .rdValid   (ioRdValid),
    .nmiReq    (nmiReq),
    .nmiDisable(nmiDisable)
  );

endmodule

// File: rtl/cmos_index_port_checker.sv
module cmos_index_port_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWrEn,
  input logic [DATA_W-1:0] ioWrData,
  input logic              ioRdEn,
  input logic [DATA_W-1:0] ioRdData,
  input logic              ioRdValid,
  input logic              iochkErr,
  input logic              serrErr,
  input logic              nmiReq,
  input logic              nmiDisable
);

  logic wrLegacy, wrAlt, rdLegacy, rdAlt;
  assign wrLegacy = ioWrEn && (ioAddr == ADDR_W'(16'h0070));
  assign wrAlt    = ioWrEn && (ioAddr == ADDR_W'(16'h0072));
  assign rdLegacy = ioRdEn && (ioAddr == ADDR_W'(16'h0070));
  assign rdAlt    = ioRdEn && !ioWrEn && (ioAddr == ADDR_W'(16'h0072));

  // R8: a set mask blocks every error source
  p_nmi_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    nmiDisable |-> !nmiReq);

  // R8: with the mask clear, an error reaches the NMI request
  p_nmi_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!nmiDisable && (iochkErr || serrErr)) |-> nmiReq);

  // R2: a legacy write loads the mask from data bit 7
  p_legacy_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrLegacy |=> (nmiDisable == $past(ioWrData[DATA_W-1])));

  // R7: an alternate-port write never touches the mask
  p_alt_keeps_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrAlt |=> $stable(nmiDisable));

  // R3: the write-only port reads all ones
  p_legacy_read_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdLegacy |=> (ioRdData == '1));

  // R5: right after a legacy write, the alternate port shows bit 7 clear
  p_alt_top_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrLegacy ##1 rdAlt |=> !ioRdData[DATA_W-1]);

  // R9: the valid strobe follows each read by exactly one cycle
  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    ioRdEn |=> ioRdValid);

  p_rd_valid_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ioRdEn |=> !ioRdValid);

endmodule

bind cmos_index_port cmos_index_port_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .ioAddr    (ioAddr),
  .ioWrEn    (ioWrEn),
  .ioWrData  (ioWrData),
  .ioRdEn    (ioRdEn),
  .ioRdData  (ioRdData),
  .ioRdValid (ioRdValid),
  .iochkErr  (iochkErr),
  .serrErr   (serrErr),
  .nmiReq    (nmiReq),
  .nmiDisable(nmiDisable)
);

// File: tb/cmos_index_port_test.sv
`timescale 1ns/1ps
module cmos_index_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWrEn = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic        ioRdEn = 1'b0;
  logic [7:0]  ioRdData;
  logic        ioRdValid;
  logic        iochkErr = 1'b0;
  logic        serrErr = 1'b0;
  logic        nmiReq;
  logic        nmiDisable;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] value;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  cmos_index_port uut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .ioWrData(ioWrData), .ioRdEn(ioRdEn), .ioRdData(ioRdData),
    .ioRdValid(ioRdValid), .iochkErr(iochkErr), .serrErr(serrErr),
    .nmiReq(nmiReq), .nmiDisable(nmiDisable)
  );

  task automatic checkBit(input logic actual, input logic expected, input string tag);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  task automatic ioWrite(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    ioAddr = addr; ioWrData = data; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  // Driver: issue a read and push what the requirements predict.
  task automatic ioRead(input logic [15:0] addr, input logic [7:0] expected, input string tag);
    expItem_t item;
    @(negedge clk);
    item.value = expected; item.tag = tag;
    expQ.push_back(item);
    ioAddr = addr; ioRdEn = 1'b1;
    @(negedge clk);
    ioRdEn = 1'b0;
  endtask

  // Monitor: compare each returned byte with the head of the queue.
  always @(negedge clk) begin
    if (rstN && ioRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected read data actual=%02h expected=none", ioRdData);
      end else begin
        expItem_t item;
        item = expQ.pop_front();
        if (ioRdData !== item.value) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", item.tag, ioRdData, item.value);
        end
      end
    end
  end

  task automatic nmiCheck(input logic chk, input logic serr, input logic expected, input string tag);
    @(negedge clk);
    iochkErr = chk; serrErr = serr;
    #1;
    checkBit(nmiReq, expected, tag);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; failures++;
          $display("FAIL watchdog actual=timeout expected=completion");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkBit(nmiDisable, 1'b1, "R1 mask set after reset");
    nmiCheck(1'b1, 1'b1, 1'b0, "R1 nmiReq blocked after reset");
    ioRead(16'h0072, 8'h00, "R1 alt port after reset");

    // R3 write-only port
    ioRead(16'h0070, 8'hFF, "R3 legacy port reads ones");

    // R2 / R8 clear the mask
    ioWrite(16'h0070, 8'h05);
    checkBit(nmiDisable, 1'b0, "R2 mask cleared by legacy write");
    nmiCheck(1'b1, 1'b0, 1'b1, "R8 iochk passes");
    nmiCheck(1'b0, 1'b1, 1'b1, "R8 serr passes");
    nmiCheck(1'b0, 1'b0, 1'b0, "R8 no error no nmi");

    // R4 RAM access at two locations
    ioWrite(16'h0071, 8'hAA);
    ioWrite(16'h0070, 8'h8A);
    checkBit(nmiDisable, 1'b1, "R2 mask set by legacy write");
    nmiCheck(1'b1, 1'b1, 1'b0, "R8 mask blocks both");
    ioWrite(16'h0071, 8'h55);
    ioWrite(16'h0070, 8'h05);
    ioRead(16'h0071, 8'hAA, "R4 RAM byte 05h");
    ioRead(16'h0072, 8'h05, "R5 alt after legacy write");

    // R6 / R7 alternate port write
    ioWrite(16'h0072, 8'h8A);
    ioRead(16'h0072, 8'h8A, "R6 alt reads all bits");
    checkBit(nmiDisable, 1'b0, "R7 alt write leaves mask");
    ioRead(16'h0071, 8'h55, "R7 alt write moves RAM address");

    // R5 bit 7 forced clear after legacy write
    ioWrite(16'h0072, 8'hFF);
    ioRead(16'h0072, 8'hFF, "R6 alt reads FFh");
    ioWrite(16'h0070, 8'h7F);
    ioRead(16'h0072, 8'h7F, "R5 alt top bit forced clear");

    // R4 boundary locations 7Fh and 00h
    ioWrite(16'h0071, 8'h3C);
    ioWrite(16'h0070, 8'h00);
    ioWrite(16'h0071, 8'hC3);
    ioWrite(16'h0070, 8'h7F);
    ioRead(16'h0071, 8'h3C, "R4 RAM byte 7Fh");
    ioWrite(16'h0070, 8'h00);
    ioRead(16'h0071, 8'hC3, "R4 RAM byte 00h");

    // R9 unmapped addresses
    ioWrite(16'h0073, 8'h12);
    ioWrite(16'h0170, 8'h85);
    ioWrite(16'h0172, 8'h85);
    ioRead(16'h0071, 8'hC3, "R9 unmapped writes leave RAM and index");
    ioRead(16'h0072, 8'h00, "R9 unmapped writes leave alt view");
    checkBit(nmiDisable, 1'b0, "R9 unmapped write leaves mask");
    ioRead(16'h0073, 8'hFF, "R9 unmapped read ones");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R9 missing read data actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule